// File: doc/BRIEF.md
# Deep-Sleep Entry and Retention Controller

This block follows the system as it drops into one of two deep-sleep states and comes back out. When the core raises a deep-sleep request while running, a single select input decides whether the system goes to Stop or to Standby. A wake event returns it to Run. Each entry sets a sticky flag that software can read afterwards. The two flags respond to different reset sources, and a self-clearing command clears them both.

On Standby entry the block can freeze two independent groups of pad outputs: general I/O and the JTAG pins. Each group has its own enable. The frozen values are driven to the pads until one cycle after the wake event. A debug-hold input, sampled at entry, prevents any capture. While the system is in Stop, a per-memory configuration vector is passed to registered shut-off enables. Both resets are synchronous and active high.

Top module: `lpm_ctrl`

## Requirements
- R1: In Run, a cycle with `sleep_req`=1 moves the mode to Stop (`sel_standby`=0) or Standby (`sel_standby`=1) at that clock edge. A request made while already in Stop or Standby is ignored.
- R2: A cycle with `wake`=1 while in Stop or Standby returns the mode to Run at that edge.
- R3: `stop_flag` rises at the edge that enters Stop. It is cleared by `rst_por`, by `rst_sys`, or by the clear command.
- R4: `sby_flag` rises at the edge that enters Standby. It is cleared by `rst_por` or by the clear command, and it keeps its value through `rst_sys`.
- R5: A one-cycle pulse on `flag_clr` is held in an internal command bit that returns to 0 by itself after one cycle. Both flags read 0 after the second edge following the pulse and not before. A flag set later stays set.
- R6: If the pending clear command and a flag set fall on the same edge, the flag ends at 1.
- R7: If `io_ret_en`=1 at Standby entry, `io_pad` shows the `io_live` value sampled at the entry edge for as long as Standby lasts, whatever `io_live` does. With no retention in effect, `io_pad` equals `io_live`.
- R8: Retained pads keep their frozen value through the wake edge and switch back to live values at the next edge.
- R9: `jtag_pad` is frozen by `jtag_ret_en` in the same way, independently of `io_ret_en`.
- R10: `dbg_hold`=1 at the Standby entry edge prevents capture for both groups, so the pads stay live.
- R11: `mem_off[i]` is a registered copy of `mem_so_cfg[i]` on every edge that leaves the mode in Stop. It is 0 in Run and Standby.
- R12: After `rst_por`, the mode is Run, both flags are 0, `mem_off` is 0 and the pads follow the live outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, clears everything |
| rst_sys | input | 1 | System reset, synchronous, spares the Standby flag |
| sleep_req | input | 1 | Deep-sleep request from the core |
| sel_standby | input | 1 | Mode select: 0 = Stop, 1 = Standby |
| wake | input | 1 | Wake event |
| flag_clr | input | 1 | Write strobe of the flag-clear command |
| dbg_hold | input | 1 | Debug hold, blocks pad capture |
| io_ret_en | input | 1 | General I/O retention enable |
| jtag_ret_en | input | 1 | JTAG pin retention enable |
| io_live | input | IO_W | Live general outputs |
| jtag_live | input | JTAG_W | Live JTAG outputs |
| mem_so_cfg | input | MEM_N | Per-memory shut-off configuration |
| stop_flag | output | 1 | Sticky Stop-entered flag |
| sby_flag | output | 1 | Sticky Standby-entered flag |
| io_pad | output | IO_W | General pad outputs |
| jtag_pad | output | JTAG_W | JTAG pad outputs |
| mem_off | output | MEM_N | Memory shut-off enables |

## Verification
Flags, mode changes and `mem_off` change at the edge that samples their cause, so they are due one edge after the stimulus. The clear command is due two edges after its pulse, and a pad release one edge after the wake edge. Pads are combinational in the live path and follow `io_live` within the same cycle. Inputs are driven 4 ns after a rising edge. A behavioural model steps on each rising edge and is compared with every output at the falling edge. Directed checks sample right after the edge at which each result is due, and one edge early where the latency itself is the requirement.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    PM_RUN     = 2'd0,
    PM_STOP    = 2'd1,
    PM_STANDBY = 2'd2
  } pmode_e;
endpackage

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_por,
  input  logic   rst_sys,
  input  logic   sleep_req,
  input  logic   sel_standby,
  input  logic   wake,
  input  logic   flag_clr,
  output pmode_e mode_q,
  output pmode_e mode_d,
  output logic   enter_stop,
  output logic   enter_sby,
  output logic   stop_flag,
  output logic   sby_flag
);
  logic any_rst;
  logic enter;
  logic clr_cmd;

  assign any_rst    = rst_por | rst_sys;
  assign enter      = sleep_req && (mode_q == PM_RUN) && !any_rst;
  assign enter_stop = enter && !sel_standby;
  assign enter_sby  = enter && sel_standby;

  always_comb begin
    mode_d = mode_q;
    if (any_rst)                          mode_d = PM_RUN;
    else if (enter)                       mode_d = sel_standby ? PM_STANDBY : PM_STOP;
    else if (wake && mode_q != PM_RUN)    mode_d = PM_RUN;
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_d;
  end

  // self-clearing command bit: lives for exactly one cycle per strobe
  always_ff @(posedge clk) begin
    if (any_rst) clr_cmd <= 1'b0;
    else         clr_cmd <= flag_clr;
  end

  always_ff @(posedge clk) begin
    if (any_rst)         stop_flag <= 1'b0;
    else if (enter_stop) stop_flag <= 1'b1;
    else if (clr_cmd)    stop_flag <= 1'b0;
  end

  // standby flag survives the system reset
  always_ff @(posedge clk) begin
    if (rst_por)                    sby_flag <= 1'b0;
    else if (enter_sby)             sby_flag <= 1'b1;
    else if (clr_cmd && !rst_sys)   sby_flag <= 1'b0;
  end

  a_r1_standby_select: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    (sleep_req && sel_standby && mode_q == PM_RUN) |=> (mode_q == PM_STANDBY));
  a_r1_busy_ignored: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    (sleep_req && !wake && mode_q != PM_RUN) |=> $stable(mode_q));
  a_r2_wake_to_run: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    (wake && mode_q != PM_RUN) |=> (mode_q == PM_RUN));
  a_r3_stop_flag_set: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    (sleep_req && !sel_standby && mode_q == PM_RUN) |=> stop_flag);
  a_r4_sby_keeps_sys: assert property (@(posedge clk) disable iff (rst_por)
    (rst_sys && sby_flag) |=> sby_flag);
  a_r5_clear_acts: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    (clr_cmd && !enter) |=> (!stop_flag && !sby_flag));
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    (clr_cmd && enter) |=> (stop_flag || sby_flag));
endmodule

// File: rtl/lpm_io_retain.sv
module lpm_io_retain #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic         free_en,
  input  logic [W-1:0] live,
  output logic [W-1:0] pad
);
  logic         held;
  logic [W-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst)          held <= 1'b0;
    else if (capture) held <= 1'b1;
    else if (free_en) held <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          snap <= '0;
    else if (capture) snap <= live;
  end

  assign pad = held ? snap : live;

  a_r7_snap_frozen: assert property (@(posedge clk) disable iff (rst)
    (held && !capture) |=> (!held || $stable(snap)));
  a_r8_hold_through_wake: assert property (@(posedge clk) disable iff (rst)
    (held && !free_en) |=> held);
endmodule

// File: rtl/lpm_mem_gate.sv
module lpm_mem_gate
  import lpm_pkg::*;
#(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  pmode_e       mode_d,
  input  pmode_e       mode_q,
  input  logic [N-1:0] cfg,
  output logic [N-1:0] off
);
  logic stop_next;
  assign stop_next = (mode_d == PM_STOP);

  for (genvar i = 0; i < N; i++) begin : g_bank
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= cfg[i] & stop_next;
    end
    assign off[i] = q;
  end

  a_r11_off_only_in_stop: assert property (@(posedge clk) disable iff (rst)
    (mode_q != PM_STOP) |-> (off == '0));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int IO_W   = 16,
  parameter int JTAG_W = 5,
  parameter int MEM_N  = 5
) (
  input  logic              clk,
  input  logic              rst_por,
  input  logic              rst_sys,
  input  logic              sleep_req,
  input  logic              sel_standby,
  input  logic              wake,
  input  logic              flag_clr,
  input  logic              dbg_hold,
  input  logic              io_ret_en,
  input  logic              jtag_ret_en,
  input  logic [IO_W-1:0]   io_live,
  input  logic [JTAG_W-1:0] jtag_live,
  input  logic [MEM_N-1:0]  mem_so_cfg,
  output logic              stop_flag,
  output logic              sby_flag,
  output logic [IO_W-1:0]   io_pad,
  output logic [JTAG_W-1:0] jtag_pad,
  output logic [MEM_N-1:0]  mem_off
);
  pmode_e mode_q;
  pmode_e mode_d;
  logic   enter_stop;
  logic   enter_sby;
  logic   any_rst;
  logic   in_run;
  logic   cap_io;
  logic   cap_jtag;

  assign any_rst  = rst_por | rst_sys;
  assign in_run   = (mode_q == PM_RUN);
  assign cap_io   = enter_sby & io_ret_en & ~dbg_hold;
  assign cap_jtag = enter_sby & jtag_ret_en & ~dbg_hold;

  lpm_mode_fsm u_fsm (
    .clk        (clk),
    .rst_por    (rst_por),
    .rst_sys    (rst_sys),
    .sleep_req  (sleep_req),
    .sel_standby(sel_standby),
    .wake       (wake),
    .flag_clr   (flag_clr),
    .mode_q     (mode_q),
    .mode_d     (mode_d),
    .enter_stop (enter_stop),
    .enter_sby  (enter_sby),
    .stop_flag  (stop_flag),
    .sby_flag   (sby_flag)
  );

  lpm_io_retain #(.W(IO_W)) u_io_ret (
    .clk    (clk),
    .rst    (any_rst),
    .capture(cap_io),
    .free_en(in_run),
    .live   (io_live),
    .pad    (io_pad)
  );

  lpm_io_retain #(.W(JTAG_W)) u_jtag_ret (
    .clk    (clk),
    .rst    (any_rst),
    .capture(cap_jtag),
    .free_en(in_run),
    .live   (jtag_live),
    .pad    (jtag_pad)
  );

  lpm_mem_gate #(.N(MEM_N)) u_mem (
    .clk   (clk),
    .rst   (any_rst),
    .mode_d(mode_d),
    .mode_q(mode_q),
    .cfg   (mem_so_cfg),
    .off   (mem_off)
  );

  a_r10_debug_blocks: assert property (@(posedge clk) disable iff (any_rst)
    (enter_sby && dbg_hold) |=> (io_pad == io_live && jtag_pad == jtag_live));
  a_r3_stop_entry_flag: assert property (@(posedge clk) disable iff (any_rst)
    enter_stop |=> (stop_flag && mode_q == PM_STOP));
endmodule

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;
  localparam int IO_W = 16, JTAG_W = 5, MEM_N = 5;

  logic clk = 0;
  logic rst_por = 1, rst_sys = 0, sleep_req = 0, sel_standby = 0, wake = 0;
  logic flag_clr = 0, dbg_hold = 0, io_ret_en = 0, jtag_ret_en = 0;
  logic [IO_W-1:0]   io_live = '0;
  logic [JTAG_W-1:0] jtag_live = '0;
  logic [MEM_N-1:0]  mem_so_cfg = '0;
  logic stop_flag, sby_flag;
  logic [IO_W-1:0]   io_pad;
  logic [JTAG_W-1:0] jtag_pad;
  logic [MEM_N-1:0]  mem_off;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  lpm_ctrl #(.IO_W(IO_W), .JTAG_W(JTAG_W), .MEM_N(MEM_N)) uut (.*);

  // behavioural reference model: 0 run, 1 stop, 2 standby
  int m_mode = 0;
  bit m_sf = 0, m_bf = 0, m_clr = 0, m_ia = 0, m_ja = 0;
  logic [IO_W-1:0]   m_ih = '0;
  logic [JTAG_W-1:0] m_jh = '0;
  logic [MEM_N-1:0]  m_off = '0;

  always @(posedge clk) begin
    bit ent;
    int nm;
    if (rst_por) begin
      m_mode = 0; m_sf = 0; m_bf = 0; m_clr = 0; m_ia = 0; m_ja = 0; m_off = '0;
    end else if (rst_sys) begin
      m_mode = 0; m_sf = 0; m_clr = 0; m_ia = 0; m_ja = 0; m_off = '0;
    end else begin
      ent = sleep_req && (m_mode == 0);
      nm = m_mode;
      if (ent) nm = sel_standby ? 2 : 1;
      else if (wake && m_mode != 0) nm = 0;
      if (ent && sel_standby && io_ret_en && !dbg_hold) begin m_ia = 1; m_ih = io_live; end
      else if (m_mode == 0) m_ia = 0;
      if (ent && sel_standby && jtag_ret_en && !dbg_hold) begin m_ja = 1; m_jh = jtag_live; end
      else if (m_mode == 0) m_ja = 0;
      if (ent && !sel_standby) m_sf = 1; else if (m_clr) m_sf = 0;
      if (ent && sel_standby)  m_bf = 1; else if (m_clr) m_bf = 0;
      m_clr = flag_clr;
      m_off = (nm == 1) ? mem_so_cfg : '0;
      m_mode = nm;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_por && !rst_sys) begin
      check("R3 model stop_flag", 32'(stop_flag), 32'(m_sf));
      check("R4 model sby_flag", 32'(sby_flag), 32'(m_bf));
      check("R7 model io_pad", 32'(io_pad), 32'(m_ia ? m_ih : io_live));
      check("R9 model jtag_pad", 32'(jtag_pad), 32'(m_ja ? m_jh : jtag_live));
      check("R11 model mem_off", 32'(mem_off), 32'(m_off));
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #4;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    rst_por = 0;
    tick();
    // R12 reset state
    io_live = 16'hA5A5; jtag_live = 5'h0B; #1;
    check("R12 stop_flag", 32'(stop_flag), 0);
    check("R12 sby_flag", 32'(sby_flag), 0);
    check("R12 mem_off", 32'(mem_off), 0);
    check("R12 io_pad live", 32'(io_pad), 32'h A5A5);

    // Stop entry
    mem_so_cfg = 5'b10110; sel_standby = 0; sleep_req = 1;
    tick(); sleep_req = 0;
    check("R3 stop_flag set", 32'(stop_flag), 1);
    check("R11 mem_off in stop", 32'(mem_off), 32'b10110);
    mem_so_cfg = 5'b01001;
    tick();
    check("R11 mem_off follows cfg", 32'(mem_off), 32'b01001);
    sel_standby = 1; sleep_req = 1;
    tick(); sleep_req = 0;
    check("R1 request in stop ignored", 32'(sby_flag), 0);
    check("R1 still in stop", 32'(mem_off), 32'b01001);
    wake = 1;
    tick(); wake = 0;
    check("R2 wake leaves stop", 32'(mem_off), 0);

    // clear command latency
    flag_clr = 1;
    tick(); flag_clr = 0;
    check("R5 not yet cleared", 32'(stop_flag), 1);
    tick();
    check("R5 cleared", 32'(stop_flag), 0);

    // Standby with general retention only
    io_ret_en = 1; jtag_ret_en = 0; io_live = 16'h1234; jtag_live = 5'h11;
    sel_standby = 1; sleep_req = 1;
    tick(); sleep_req = 0;
    io_live = 16'hBEEF; jtag_live = 5'h06; #1;
    check("R4 sby_flag set", 32'(sby_flag), 1);
    check("R7 io held", 32'(io_pad), 32'h1234);
    check("R9 jtag live w/o enable", 32'(jtag_pad), 32'h06);
    check("R11 mem_off in standby", 32'(mem_off), 0);
    tick(3);
    io_live = 16'h0F0F; #1;
    check("R7 io still held", 32'(io_pad), 32'h1234);
    wake = 1;
    tick(); wake = 0;
    check("R8 held through wake edge", 32'(io_pad), 32'h1234);
    tick();
    check("R8 released", 32'(io_pad), 32'h0F0F);

    // system reset keeps standby flag, clears stop flag
    sel_standby = 0; sleep_req = 1;
    tick(); sleep_req = 0;
    rst_sys = 1;
    tick(); rst_sys = 0;
    check("R4 sby survives rst_sys", 32'(sby_flag), 1);
    check("R3 stop cleared by rst_sys", 32'(stop_flag), 0);

    // set wins over pending clear
    flag_clr = 1;
    tick(); flag_clr = 0;
    sel_standby = 0; sleep_req = 1;
    tick(); sleep_req = 0;
    check("R6 set wins", 32'(stop_flag), 1);
    check("R6 other flag cleared", 32'(sby_flag), 0);
    tick();
    check("R5 single strobe acts once", 32'(stop_flag), 1);
    wake = 1; tick(); wake = 0;

    // debug hold blocks capture
    io_ret_en = 1; jtag_ret_en = 1; dbg_hold = 1;
    io_live = 16'h5555; jtag_live = 5'h15;
    sel_standby = 1; sleep_req = 1;
    tick(); sleep_req = 0; dbg_hold = 0;
    io_live = 16'h6666; jtag_live = 5'h0A; #1;
    check("R10 io live under debug", 32'(io_pad), 32'h6666);
    check("R10 jtag live under debug", 32'(jtag_pad), 32'h0A);
    wake = 1; tick(); wake = 0; tick();

    // JTAG-only retention
    io_ret_en = 0; jtag_ret_en = 1; jtag_live = 5'h1C; io_live = 16'h7777;
    sleep_req = 1;
    tick(); sleep_req = 0;
    jtag_live = 5'h03; io_live = 16'h8888; #1;
    check("R9 jtag held", 32'(jtag_pad), 32'h1C);
    check("R9 io live", 32'(io_pad), 32'h8888);
    wake = 1; tick(); wake = 0; tick();
    check("R8 jtag released", 32'(jtag_pad), 32'h03);

    // power-on reset clears standby flag
    check("R4 sby set before por", 32'(sby_flag), 1);
    rst_por = 1;
    tick(); rst_por = 0;
    check("R4 por clears sby", 32'(sby_flag), 0);
    check("R12 por mem_off", 32'(mem_off), 0);
    tick(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule